// File: doc/BRIEF.md
# Dual-Slot Clock Source Programmer

This block moves a processor clock to a new operating point by producing an ordered series of register updates for a clock generator that has two selectable source slots. Each slot carries a 3-bit source select and a 4-bit divider. A single bit in a second register names the active slot. The block writes only the slot that is currently idle and then toggles the active-slot bit, so the running clock changes in one step and never passes through a half-programmed setting.

The same select register holds a 2-bit bus-clock divider. When a new operating point needs a larger bus divider, the block writes it before the source switch. When it needs a smaller one, the block writes it after the switch. When the value is the same, the block leaves the field alone. Before any of this, the block ORs a fixed wait-state count into the control register. A caller pulses `start` with the target select, divider and bus divider. It reads the two register images and waits for the one-cycle `done` pulse.

Top module: `clksrc_prog`

## Requirements
- R1: After a synchronous active-low reset, `ctrl_img` and `sel_img` are all zero (slot 0 active, select 0, divider 0, bus divider 0) and `done` is low.
- R2: `sel_img[0]` names the active slot. When it is 0, the select is written to `ctrl_img[6:4]` and the divider to `ctrl_img[3:0]`, and the bit is then set to 1. When it is 1, `ctrl_img[14:12]` and `ctrl_img[11:8]` are written instead, and the bit is then cleared.
- R3: Each sequence makes exactly one register update per clock. The order is: wait-state merge, optional early bus write, source select, divider, active-slot toggle, optional late bus write.
- R4: If the requested bus divider is greater than `sel_img[2:1]`, it is written to `sel_img[2:1]` in the cycle after the wait-state merge and before the source select.
- R5: If the requested bus divider is less than `sel_img[2:1]`, it is written in the cycle after the active-slot toggle.
- R6: If the requested bus divider equals `sel_img[2:1]`, that field is not rewritten and the sequence takes four update cycles.
- R7: The first update of every sequence ORs the value 100 into `ctrl_img[22:16]` and leaves every other bit unchanged.
- R8: Each update changes only its own field. The slot that was active when the sequence started keeps its select and divider throughout.
- R9: A `start` pulse that arrives while a sequence is running has no effect on the running sequence and does not begin another one.
- R10: `done` is high for exactly one cycle, in the cycle in which the final update is visible. With `start` sampled at edge N, that is after edge N+4, or after edge N+5 when the bus divider changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe; sampled only when the block is idle |
| req_src | input | 3 | Target source select |
| req_div | input | 4 | Target source divider |
| req_bus | input | 2 | Target bus-clock divider |
| ctrl_img | output | 32 | Control register image (slot fields and wait-state count) |
| sel_img | output | 3 | Select register image: bit 0 active slot, bits [2:1] bus divider |
| done | output | 1 | One-cycle pulse when a sequence completes |

## Verification
The assertions assume that the two register images change only through this block's own sequence. They also assume that reset is held for at least one clock edge, so that every `$past` value is a defined reset value. The bench meets both conditions: it holds reset for three edges, and it drives `start` only at falling edges, either when the block is idle or deliberately in the middle of a sequence to exercise R9. The targets it chooses cover a rising, an equal and a falling bus divider, starting from both values of the active-slot bit. Because of this, every assertion, including the per-slot stability properties, is exercised with each slot active at some point.

// File: rtl/clksrc_pkg.sv
// Shared types for the dual-slot clock source programmer.
// Assumes nothing beyond standard enum encoding.
package clksrc_pkg;

    // Register update performed on a given clock edge
    typedef enum logic [2:0] {
        OP_NONE,
        OP_WAIT,
        OP_BUS,
        OP_SEL,
        OP_DIV,
        OP_FLIP
    } wr_op_e;

    // Sequencer state
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_BUS_PRE,
        ST_SEL,
        ST_DIV,
        ST_FLIP,
        ST_BUS_POST
    } seq_st_e;

    // Direction of the bus divider change, decided at request time
    typedef enum logic [1:0] {
        BUS_KEEP,
        BUS_RAISE,
        BUS_LOWER
    } bus_dir_e;

endpackage

// File: rtl/clksrc_seq_fsm.sv
// Sequencer: accepts a request while idle, latches the targets, and steps
// through one register update per cycle. It decides once, at request time,
// whether the bus divider goes before the switch, after it, or not at all.
// Assumes cur_bus reflects the register image at the cycle start is sampled.
module clksrc_seq_fsm
    import clksrc_pkg::*;
#(
    parameter int SRC_W = 3,
    parameter int DIV_W = 4,
    parameter int BUS_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [SRC_W-1:0] req_src,
    input  logic [DIV_W-1:0] req_div,
    input  logic [BUS_W-1:0] req_bus,
    input  logic [BUS_W-1:0] cur_bus,
    output wr_op_e           op,
    output logic [SRC_W-1:0] hold_src,
    output logic [DIV_W-1:0] hold_div,
    output logic [BUS_W-1:0] hold_bus,
    output logic             done
);

    seq_st_e  st_q;
    bus_dir_e dir_q;
    bus_dir_e dir_d;

    // Classify the requested bus divider against the current one
    always_comb begin
        if (req_bus > cur_bus)
            dir_d = BUS_RAISE;
        else if (req_bus < cur_bus)
            dir_d = BUS_LOWER;
        else
            dir_d = BUS_KEEP;
    end

    // State register, target latch and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            dir_q    <= BUS_KEEP;
            hold_src <= '0;
            hold_div <= '0;
            hold_bus <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        hold_src <= req_src;
                        hold_div <= req_div;
                        hold_bus <= req_bus;
                        dir_q    <= dir_d;
                        st_q     <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    st_q <= (dir_q == BUS_RAISE) ? ST_BUS_PRE : ST_SEL;
                end
                ST_BUS_PRE: begin
                    st_q <= ST_SEL;
                end
                ST_SEL: begin
                    st_q <= ST_DIV;
                end
                ST_DIV: begin
                    st_q <= ST_FLIP;
                end
                ST_FLIP: begin
                    if (dir_q == BUS_LOWER) begin
                        st_q <= ST_BUS_POST;
                    end else begin
                        st_q <= ST_IDLE;
                        done <= 1'b1;
                    end
                end
                ST_BUS_POST: begin
                    st_q <= ST_IDLE;
                    done <= 1'b1;
                end
                default: begin
                    st_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Map the state to the register update it performs on the next edge
    always_comb begin
        case (st_q)
            ST_WAIT:     op = OP_WAIT;
            ST_BUS_PRE:  op = OP_BUS;
            ST_SEL:      op = OP_SEL;
            ST_DIV:      op = OP_DIV;
            ST_FLIP:     op = OP_FLIP;
            ST_BUS_POST: op = OP_BUS;
            default:     op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/clksrc_slot_field.sv
// Next-value logic for one source slot of the control register.
// The slot's fields change only when the slot is idle (act_bit differs from
// SLOT_ID) and the operation targets its select or divider field.
// Assumes STRIDE is at least DIV_W + SRC_W; the bits above are preserved.
module clksrc_slot_field
    import clksrc_pkg::*;
#(
    parameter int SLOT_ID = 0,
    parameter int SRC_W   = 3,
    parameter int DIV_W   = 4,
    parameter int STRIDE  = 8
) (
    input  logic [STRIDE-1:0] region_cur,
    input  logic              act_bit,
    input  wr_op_e            op,
    input  logic [SRC_W-1:0]  src,
    input  logic [DIV_W-1:0]  div,
    output logic [STRIDE-1:0] region_nxt
);

    localparam logic MY_ID = 1'(SLOT_ID);

    // Read-modify-write of this slot's select or divider field
    always_comb begin
        region_nxt = region_cur;
        if (act_bit != MY_ID) begin
            if (op == OP_SEL)
                region_nxt[DIV_W +: SRC_W] = src;
            if (op == OP_DIV)
                region_nxt[0 +: DIV_W] = div;
        end
    end

endmodule

// File: rtl/clksrc_reg_image.sv
// Holds the control and select register images and applies one update per
// cycle as directed by the sequencer. Slot j lives at bit (1-j)*STRIDE, so
// the slot chosen when the active bit is 0 is the low one.
// Assumes the wait-state field lies above both slot regions.
module clksrc_reg_image
    import clksrc_pkg::*;
#(
    parameter int CTRL_W   = 32,
    parameter int SRC_W    = 3,
    parameter int DIV_W    = 4,
    parameter int BUS_W    = 2,
    parameter int STRIDE   = 8,
    parameter int WAIT_LSB = 16,
    parameter int WAIT_W   = 7,
    parameter int WAIT_VAL = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_op_e            op,
    input  logic [SRC_W-1:0]  src,
    input  logic [DIV_W-1:0]  div,
    input  logic [BUS_W-1:0]  bus,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [BUS_W:0]    sel_q
);

    localparam int N_SLOTS = 2;
    localparam logic [WAIT_W-1:0] WAIT_BITS = WAIT_W'(WAIT_VAL);

    logic [STRIDE-1:0] slot_nx [N_SLOTS];
    logic [CTRL_W-1:0] ctrl_d;
    logic [BUS_W:0]    sel_d;

    // One field-update instance per source slot
    for (genvar j = 0; j < N_SLOTS; j++) begin : g_slot
        localparam int BASE = (N_SLOTS - 1 - j) * STRIDE;
        clksrc_slot_field #(
            .SLOT_ID (j),
            .SRC_W   (SRC_W),
            .DIV_W   (DIV_W),
            .STRIDE  (STRIDE)
        ) slot_i (
            .region_cur (ctrl_q[BASE +: STRIDE]),
            .act_bit    (sel_q[0]),
            .op         (op),
            .src        (src),
            .div        (div),
            .region_nxt (slot_nx[j])
        );
    end

    // Assemble the next control image from the slot results and wait merge
    always_comb begin
        ctrl_d = ctrl_q;
        for (int j = 0; j < N_SLOTS; j++)
            ctrl_d[(N_SLOTS - 1 - j) * STRIDE +: STRIDE] = slot_nx[j];
        if (op == OP_WAIT)
            ctrl_d[WAIT_LSB +: WAIT_W] = ctrl_q[WAIT_LSB +: WAIT_W] | WAIT_BITS;
    end

    // Next select image: bus divider write or active-slot toggle
    always_comb begin
        sel_d = sel_q;
        if (op == OP_BUS)
            sel_d[BUS_W:1] = bus;
        if (op == OP_FLIP)
            sel_d[0] = ~sel_q[0];
    end

    // Register images
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            sel_q  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            sel_q  <= sel_d;
        end
    end

endmodule

// File: rtl/clksrc_prog.sv
// Top of the dual-slot clock source programmer. Connects the sequencer to
// the register images; the images are the block's outputs.
// Assumes the outputs are the only copy of the two registers.
module clksrc_prog
    import clksrc_pkg::*;
#(
    parameter int CTRL_W   = 32,
    parameter int SRC_W    = 3,
    parameter int DIV_W    = 4,
    parameter int BUS_W    = 2,
    parameter int STRIDE   = 8,
    parameter int WAIT_LSB = 16,
    parameter int WAIT_W   = 7,
    parameter int WAIT_VAL = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [DIV_W-1:0]  req_div,
    input  logic [BUS_W-1:0]  req_bus,
    output logic [CTRL_W-1:0] ctrl_img,
    output logic [BUS_W:0]    sel_img,
    output logic              done
);

    wr_op_e           op;
    logic [SRC_W-1:0] hold_src;
    logic [DIV_W-1:0] hold_div;
    logic [BUS_W-1:0] hold_bus;

    clksrc_seq_fsm #(
        .SRC_W (SRC_W),
        .DIV_W (DIV_W),
        .BUS_W (BUS_W)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .req_src  (req_src),
        .req_div  (req_div),
        .req_bus  (req_bus),
        .cur_bus  (sel_img[BUS_W:1]),
        .op       (op),
        .hold_src (hold_src),
        .hold_div (hold_div),
        .hold_bus (hold_bus),
        .done     (done)
    );

    clksrc_reg_image #(
        .CTRL_W   (CTRL_W),
        .SRC_W    (SRC_W),
        .DIV_W    (DIV_W),
        .BUS_W    (BUS_W),
        .STRIDE   (STRIDE),
        .WAIT_LSB (WAIT_LSB),
        .WAIT_W   (WAIT_W),
        .WAIT_VAL (WAIT_VAL)
    ) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .src    (hold_src),
        .div    (hold_div),
        .bus    (hold_bus),
        .ctrl_q (ctrl_img),
        .sel_q  (sel_img)
    );

endmodule

// File: rtl/clksrc_prog_chk.sv
// Property checker for clksrc_prog, attached by bind below.
// Assumes reset is held for at least one clock edge.
module clksrc_prog_chk #(
    parameter int CTRL_W   = 32,
    parameter int BUS_W    = 2,
    parameter int STRIDE   = 8,
    parameter int WAIT_LSB = 16,
    parameter int WAIT_W   = 7,
    parameter int WAIT_VAL = 100
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CTRL_W-1:0] ctrl_img,
    input logic [BUS_W:0]    sel_img,
    input logic              done
);

    localparam logic [WAIT_W-1:0] WAIT_BITS = WAIT_W'(WAIT_VAL);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_final_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !$stable(sel_img));

    // R3
    one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(ctrl_img) && !$stable(sel_img)));

    // R7
    wait_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_img[WAIT_LSB +: WAIT_W]) == WAIT_BITS)
            |-> (ctrl_img[WAIT_LSB +: WAIT_W] == WAIT_BITS));

    // R8
    slot_hi_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_img[0] && !$past(sel_img[0]))
            |-> $stable(ctrl_img[STRIDE +: STRIDE]));

    // R8
    slot_lo_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_img[0] && $past(sel_img[0]))
            |-> $stable(ctrl_img[0 +: STRIDE]));

endmodule

bind clksrc_prog clksrc_prog_chk #(
    .CTRL_W   (CTRL_W),
    .BUS_W    (BUS_W),
    .STRIDE   (STRIDE),
    .WAIT_LSB (WAIT_LSB),
    .WAIT_W   (WAIT_W),
    .WAIT_VAL (WAIT_VAL)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_img (ctrl_img),
    .sel_img  (sel_img),
    .done     (done)
);

// File: tb/clksrc_prog_tb_top.sv
// Directed bench for clksrc_prog: one task per scenario, each checking its
// own results against a model built from the requirements.
module clksrc_prog_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  req_src = '0;
    logic [3:0]  req_div = '0;
    logic [1:0]  req_bus = '0;
    logic [31:0] ctrl_img;
    logic [2:0]  sel_img;
    logic        done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [31:0] m_ctrl = '0;
    logic [2:0]  m_sel  = '0;

    always #4 clk = ~clk;

    clksrc_prog dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .req_src  (req_src),
        .req_div  (req_div),
        .req_bus  (req_bus),
        .ctrl_img (ctrl_img),
        .sel_img  (sel_img),
        .done     (done)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Step codes: 0 wait, 1 early bus, 2 select, 3 divider, 4 toggle, 5 late bus
    task automatic model_step(int code, logic [2:0] s, logic [3:0] d, logic [1:0] b);
        case (code)
            0: m_ctrl[22:16] = m_ctrl[22:16] | 7'd100;
            1, 5: m_sel[2:1] = b;
            2: if (m_sel[0] == 1'b0) m_ctrl[6:4] = s; else m_ctrl[14:12] = s;
            3: if (m_sel[0] == 1'b0) m_ctrl[3:0] = d; else m_ctrl[11:8] = d;
            4: m_sel[0] = ~m_sel[0];
            default: ;
        endcase
    endtask

    function automatic string step_req(int code);
        case (code)
            0: return "R7";
            1: return "R4";
            2: return "R2";
            3: return "R3";
            4: return "R2";
            default: return "R5";
        endcase
    endfunction

    // Run one sequence; inj >= 0 pulses a stray start before update number inj
    task automatic run_seq(logic [2:0] s, logic [3:0] d, logic [1:0] b, int inj);
        int ops[6];
        int n = 0;
        logic [7:0] old_region;
        logic old_act;
        old_act = m_sel[0];
        old_region = old_act ? m_ctrl[7:0] : m_ctrl[15:8];
        ops[n] = 0; n++;
        if (b > m_sel[2:1]) begin ops[n] = 1; n++; end
        ops[n] = 2; n++;
        ops[n] = 3; n++;
        ops[n] = 4; n++;
        if (b < m_sel[2:1]) begin ops[n] = 5; n++; end
        req_src = s; req_div = d; req_bus = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < n; k++) begin
            if (k == inj) begin
                start = 1'b1; req_src = ~s; req_div = ~d; req_bus = ~b;
            end
            @(negedge clk);
            start = 1'b0;
            model_step(ops[k], s, d, b);
            chk(step_req(ops[k]), "ctrl_img", ctrl_img, m_ctrl);
            chk(step_req(ops[k]), "sel_img", {29'd0, sel_img}, {29'd0, m_sel});
            chk("R10", "done", {31'd0, done}, {31'd0, (k == n - 1)});
        end
        chk("R8", "old active slot", {24'd0, old_act ? ctrl_img[7:0] : ctrl_img[15:8]},
            {24'd0, old_region});
        @(negedge clk);
        chk("R10", "done after", {31'd0, done}, 32'd0);
        chk("R9", "ctrl stable after", ctrl_img, m_ctrl);
        chk("R9", "sel stable after", {29'd0, sel_img}, {29'd0, m_sel});
    endtask

    task automatic t_reset();
        chk("R1", "ctrl_img", ctrl_img, 32'd0);
        chk("R1", "sel_img", {29'd0, sel_img}, 32'd0);
        chk("R1", "done", {31'd0, done}, 32'd0);
    endtask

    task automatic t_raise_bus();
        run_seq(3'd5, 4'd3, 2'd2, -1);
        chk("R2", "low slot select", {29'd0, ctrl_img[6:4]}, 32'd5);
        chk("R4", "bus raised", {30'd0, sel_img[2:1]}, 32'd2);
    endtask

    task automatic t_equal_bus();
        run_seq(3'd2, 4'd9, 2'd2, -1);
        chk("R2", "high slot divider", {28'd0, ctrl_img[11:8]}, 32'd9);
        chk("R2", "active bit cleared", {31'd0, sel_img[0]}, 32'd0);
        chk("R6", "bus unchanged", {30'd0, sel_img[2:1]}, 32'd2);
    endtask

    task automatic t_lower_bus();
        run_seq(3'd7, 4'd1, 2'd0, -1);
        chk("R5", "bus lowered", {30'd0, sel_img[2:1]}, 32'd0);
    endtask

    task automatic t_busy_start();
        run_seq(3'd3, 4'd6, 2'd0, 1);
        run_seq(3'd1, 4'd14, 2'd3, 3);
        chk("R9", "final select", {29'd0, ctrl_img[6:4]}, 32'd1);
    endtask

    task automatic t_idle_quiet();
        repeat (4) @(negedge clk);
        chk("R9", "idle ctrl", ctrl_img, m_ctrl);
        chk("R9", "idle sel", {29'd0, sel_img}, {29'd0, m_sel});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_raise_bus();
        t_equal_bus();
        t_lower_bus();
        t_busy_start();
        t_idle_quiet();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule